// File: doc/BRIEF.md
# Ten-Bit Parity Code Packer and Loader

This block converts an eight-symbol parity code, ten bits per symbol, between the form a parity generator produces and the form kept in a page's spare area. On the write side, four 32-bit parity words arrive together. Each word carries one symbol in its low field and one in its upper field. The block discards every bit outside those two fields and sends the ten resulting bytes out one at a time over a valid/ready stream.

On the read side, the ten bytes fetched from the spare area arrive in one transfer. If every byte is 0xFF, the page has never been programmed. The block raises a one-cycle erased indication and issues no loads. Otherwise it splits the bytes into eight symbols and delivers them one per cycle to the load port of a syndrome engine, highest index first. A stall input on that port pauses the sequence without losing a symbol.

Top module: `ecc10_codec`

## Requirements
- R1: From parity word w (w in 0..3, carried on par_words[32w+31:32w]), only bits [9:0] (symbol 2w) and bits [25:16] (symbol 2w+1) reach the output. All other bits have no effect on any output byte.
- R2: Within each five-byte group built from words p0 and p1, the bytes are: byte 0 = p0[7:0], byte 1 = {p0[21:16], p0[9:8]}, byte 2 = {p1[3:0], p0[25:22]}, byte 3 = {p1[17:16], p1[9:4]}, byte 4 = p1[25:18].
- R3: The stream carries bytes 0..4 from words 0 and 1 first, then bytes 5..9 from words 2 and 3. A stored byte index k maps to rd_bytes[8k+7:8k].
- R4: ob_last is high exactly with the tenth byte. After that byte is accepted, ob_valid drops in the next cycle.
- R5: While ob_valid is high and ob_ready is low, ob_valid stays high and ob_data and ob_last hold their values.
- R6: par_ready is low from the cycle after a request is accepted until the tenth byte is accepted. A request offered in that window is neither taken nor allowed to disturb the stream in progress.
- R7: A read transfer whose ten bytes are all 0xFF produces a one-cycle rd_erased pulse in the cycle after acceptance and no ld_strobe.
- R8: Symbol i of a read transfer is bits [10i+9:10i] of the 80-bit little-endian value made of the ten bytes, i.e. five little-endian 16-bit words.
- R9: A non-erased transfer produces exactly eight strobes, with ld_index going 7, 6, ..., 0. The first strobe comes in the cycle after acceptance, and strobes are back-to-back while ld_stall is low. ld_last is high with index 0.
- R10: While ld_stall is high, ld_strobe is low and the pending index and value are held.
- R11: rd_ready is low while a load sequence is pending, and high again in the cycle after the last strobe.
- R12: In reset, ob_valid, ld_strobe and rd_erased are low, and par_ready and rd_ready are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| par_valid | input | 1 | Parity words offered |
| par_ready | output | 1 | Packer idle, able to take words |
| par_words | input | 128 | Four parity words, word 0 in bits [31:0] |
| ob_valid | output | 1 | Output byte valid |
| ob_ready | input | 1 | Sink takes the byte |
| ob_data | output | 8 | Stored-form byte |
| ob_last | output | 1 | Tenth byte of the code |
| rd_valid | input | 1 | Stored bytes offered |
| rd_ready | output | 1 | Loader idle, able to take bytes |
| rd_bytes | input | 80 | Ten stored bytes, byte 0 in bits [7:0] |
| rd_erased | output | 1 | One-cycle pulse: all bytes were 0xFF |
| ld_strobe | output | 1 | Load one symbol |
| ld_value | output | 10 | Symbol value |
| ld_index | output | 3 | Symbol index |
| ld_last | output | 1 | Final symbol of the sequence |
| ld_stall | input | 1 | Load port cannot accept this cycle |

## Verification
The assertions assume the byte sink and the load port follow their handshakes. They also assume a request is counted only when valid and ready are high together. They place no constraint on words offered while the matching ready is low. The stimulus drives every input at the falling edge. It keeps offering new parity words throughout a stream, so the hold-off is exercised without breaking that assumption. It also varies ob_ready and ld_stall by pattern, so stalls land on first, middle and last elements.

// File: rtl/ecc10_pkg.sv
package ecc10_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] BLANK_BYTE = 8'hFF;
  typedef enum logic {ST_IDLE, ST_RUN} run_st_e;
endpackage

// File: rtl/ecc10_packer.sv
module ecc10_packer
  import ecc10_pkg::*;
#(
  parameter int SYM_W   = 10,
  parameter int NUM_SYM = 8,
  parameter int WORD_W  = 32,
  parameter int HI_LSB  = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          par_valid,
  output logic                          par_ready,
  input  logic [NUM_SYM/2*WORD_W-1:0]   par_words,
  output logic                          ob_valid,
  input  logic                          ob_ready,
  output logic [BYTE_W-1:0]             ob_data,
  output logic                          ob_last
);
  localparam int NUM_WORDS = NUM_SYM / 2;
  localparam int CODE_W    = NUM_SYM * SYM_W;
  localparam int NUM_BYTES = CODE_W / BYTE_W;
  localparam int CNT_W     = $clog2(NUM_BYTES);

  logic [CODE_W-1:0] code_in;
  logic [CODE_W-1:0] code_q, code_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  run_st_e           st_q, st_d;
  logic [BYTE_W-1:0] byte_arr [NUM_BYTES];

  // Select the two symbol fields of each word; the rest is dropped.
  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    for (genvar h = 0; h < 2; h++) begin : g_half
      assign code_in[(2*w+h)*SYM_W +: SYM_W] = par_words[w*WORD_W + h*HI_LSB +: SYM_W];
    end
  end

  // Symbols laid end to end form the stored byte image.
  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
    assign byte_arr[b] = code_q[b*BYTE_W +: BYTE_W];
  end

  logic take, send, at_end;
  assign par_ready = (st_q == ST_IDLE);
  assign take      = par_valid && par_ready;
  assign ob_valid  = (st_q == ST_RUN);
  assign at_end    = (cnt_q == CNT_W'(NUM_BYTES - 1));
  assign send      = ob_valid && ob_ready;
  assign ob_data   = byte_arr[cnt_q];
  assign ob_last   = ob_valid && at_end;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    code_d = code_q;
    if (take) begin
      st_d   = ST_RUN;
      cnt_d  = '0;
      code_d = code_in;
    end else if (send) begin
      if (at_end) begin
        st_d  = ST_IDLE;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (take) code_q <= code_d;
  end

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ob_valid && !ob_ready |=> ob_valid && $stable(ob_data) && $stable(ob_last));
  p_holdoff_r6: assert property (@(posedge clk) disable iff (!rst_n)
    par_valid && par_ready |=> ob_valid && !par_ready);
  p_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ob_valid && ob_ready && ob_last |=> !ob_valid && par_ready);
endmodule

// File: rtl/ecc10_erase_det.sv
module ecc10_erase_det
  import ecc10_pkg::*;
#(
  parameter int NUM_BYTES = 10
) (
  input  logic [NUM_BYTES*BYTE_W-1:0] code,
  output logic                        blank
);
  logic [NUM_BYTES-1:0] byte_blank;
  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_cmp
    assign byte_blank[b] = (code[b*BYTE_W +: BYTE_W] == BLANK_BYTE);
  end
  assign blank = &byte_blank;
endmodule

// File: rtl/ecc10_loader.sv
module ecc10_loader
  import ecc10_pkg::*;
#(
  parameter int SYM_W   = 10,
  parameter int NUM_SYM = 8
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               rd_valid,
  output logic                               rd_ready,
  input  logic [NUM_SYM*SYM_W-1:0]           rd_bytes,
  output logic                               rd_erased,
  output logic                               ld_strobe,
  output logic [SYM_W-1:0]                   ld_value,
  output logic [$clog2(NUM_SYM)-1:0]         ld_index,
  output logic                               ld_last,
  input  logic                               ld_stall
);
  localparam int CODE_W    = NUM_SYM * SYM_W;
  localparam int NUM_BYTES = CODE_W / BYTE_W;
  localparam int IDX_W     = $clog2(NUM_SYM);

  logic              blank;
  logic [CODE_W-1:0] code_q;
  logic [IDX_W-1:0]  idx_q, idx_d;
  run_st_e           st_q, st_d;
  logic              ers_q, ers_d;
  logic [SYM_W-1:0]  sym [NUM_SYM];

  ecc10_erase_det #(.NUM_BYTES(NUM_BYTES)) i_det (
    .code  (rd_bytes),
    .blank (blank)
  );

  // Little-endian byte image: symbol i occupies bits [SYM_W*i +: SYM_W].
  for (genvar s = 0; s < NUM_SYM; s++) begin : g_sym
    assign sym[s] = code_q[s*SYM_W +: SYM_W];
  end

  logic take;
  assign rd_ready  = (st_q == ST_IDLE);
  assign take      = rd_valid && rd_ready;
  assign ld_strobe = (st_q == ST_RUN) && !ld_stall;
  assign ld_index  = idx_q;
  assign ld_value  = sym[idx_q];
  assign ld_last   = (st_q == ST_RUN) && (idx_q == '0);
  assign rd_erased = ers_q;

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    ers_d = take && blank;
    if (take && !blank) begin
      st_d  = ST_RUN;
      idx_d = IDX_W'(NUM_SYM - 1);
    end else if (ld_strobe) begin
      if (idx_q == '0) st_d = ST_IDLE;
      else             idx_d = idx_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      idx_q <= '0;
      ers_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
      ers_q <= ers_d;
    end
  end

  always_ff @(posedge clk) begin
    if (take && !blank) code_q <= rd_bytes;
  end

  p_erase_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && rd_ready && blank |=> rd_erased && !ld_strobe);
  p_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && rd_ready && !blank |=> ld_index == IDX_W'(NUM_SYM - 1) && !rd_ready);
  p_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ld_strobe && !ld_last |=> ld_index == $past(ld_index) - 1'b1);
  p_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_ready && ld_stall |=> !rd_ready && $stable(ld_index) && $stable(ld_value));
  p_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ld_strobe && ld_last |=> rd_ready && !ld_strobe);
endmodule

// File: rtl/ecc10_codec.sv
module ecc10_codec
  import ecc10_pkg::*;
#(
  parameter int SYM_W   = 10,
  parameter int NUM_SYM = 8,
  parameter int WORD_W  = 32,
  parameter int HI_LSB  = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         par_valid,
  output logic                         par_ready,
  input  logic [NUM_SYM/2*WORD_W-1:0]  par_words,
  output logic                         ob_valid,
  input  logic                         ob_ready,
  output logic [7:0]                   ob_data,
  output logic                         ob_last,
  input  logic                         rd_valid,
  output logic                         rd_ready,
  input  logic [NUM_SYM*SYM_W-1:0]     rd_bytes,
  output logic                         rd_erased,
  output logic                         ld_strobe,
  output logic [SYM_W-1:0]             ld_value,
  output logic [$clog2(NUM_SYM)-1:0]   ld_index,
  output logic                         ld_last,
  input  logic                         ld_stall
);
  // Reset asserts at once, deasserts two clocks after rst_n rises.
  logic [1:0] rst_sync_q;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  ecc10_packer #(.SYM_W(SYM_W), .NUM_SYM(NUM_SYM), .WORD_W(WORD_W), .HI_LSB(HI_LSB)) i_pack (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .par_valid (par_valid),
    .par_ready (par_ready),
    .par_words (par_words),
    .ob_valid  (ob_valid),
    .ob_ready  (ob_ready),
    .ob_data   (ob_data),
    .ob_last   (ob_last)
  );

  ecc10_loader #(.SYM_W(SYM_W), .NUM_SYM(NUM_SYM)) i_load (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .rd_valid  (rd_valid),
    .rd_ready  (rd_ready),
    .rd_bytes  (rd_bytes),
    .rd_erased (rd_erased),
    .ld_strobe (ld_strobe),
    .ld_value  (ld_value),
    .ld_index  (ld_index),
    .ld_last   (ld_last),
    .ld_stall  (ld_stall)
  );
endmodule

// File: tb/test_ecc10_codec.sv
module test_ecc10_codec;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         par_valid, ob_ready, rd_valid, ld_stall;
  logic [127:0] par_words;
  logic [79:0]  rd_bytes;
  logic         par_ready, ob_valid, ob_last, rd_ready, rd_erased, ld_strobe, ld_last;
  logic [7:0]   ob_data;
  logic [9:0]   ld_value;
  logic [2:0]   ld_index;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  ecc10_codec i_ecc10_codec (
    .clk(clk), .rst_n(rst_n), .par_valid(par_valid), .par_ready(par_ready),
    .par_words(par_words), .ob_valid(ob_valid), .ob_ready(ob_ready),
    .ob_data(ob_data), .ob_last(ob_last), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_bytes(rd_bytes), .rd_erased(rd_erased), .ld_strobe(ld_strobe),
    .ld_value(ld_value), .ld_index(ld_index), .ld_last(ld_last), .ld_stall(ld_stall)
  );

  localparam logic [127:0] VEC [5] = '{
    128'h0,
    128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF,
    128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210,
    128'hFC00_FC00_FC00_FC00_FC00_FC00_FC00_FC00,
    128'h0155_02AA_03C3_0111_0200_0001_0300_0080
  };

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [79:0] exp_pack(input logic [127:0] w);
    logic [79:0] r;
    logic [31:0] p0, p1;
    for (int q = 0; q < 2; q++) begin
      p0 = w[64*q +: 32] & 32'h03FF03FF;
      p1 = w[64*q+32 +: 32] & 32'h03FF03FF;
      r[40*q +: 8]    = p0[7:0];
      r[40*q+8 +: 8]  = {p0[21:16], p0[9:8]};
      r[40*q+16 +: 8] = {p1[3:0], p0[25:22]};
      r[40*q+24 +: 8] = {p1[17:16], p1[9:4]};
      r[40*q+32 +: 8] = p1[25:18];
    end
    return r;
  endfunction

  function automatic logic [9:0] exp_sym(input logic [79:0] b, input int i);
    logic [79:0] flat;
    for (int k = 0; k < 5; k++) flat[16*k +: 16] = {b[16*k+8 +: 8], b[16*k +: 8]};
    return flat[10*i +: 10];
  endfunction

  task automatic do_pack(input logic [127:0] w, input int stall_mode);
    logic [79:0] e = exp_pack(w);
    int j = 0, t = 0;
    @(negedge clk);
    chk(par_ready == 1'b1, "R6 idle ready", 128'(par_ready), 128'd1);
    par_valid = 1'b1; par_words = w;
    @(posedge clk);
    @(negedge clk);
    par_words = ~w;  // held-off request stays offered during the stream
    while (j < 10) begin
      ob_ready = (stall_mode == 0) ? 1'b1 : ((t % 3) != 1);
      chk(ob_valid == 1'b1, "R5 valid held", 128'(ob_valid), 128'd1);
      chk(par_ready == 1'b0, "R6 busy", 128'(par_ready), 128'd0);
      if (ob_ready) begin
        chk(ob_data == e[8*j +: 8], "R1 R2 R3 byte", 128'(ob_data), 128'(e[8*j +: 8]));
        chk(ob_last == (j == 9), "R4 last", 128'(ob_last), 128'(j == 9));
        j++;
      end
      t++;
      @(posedge clk);
      @(negedge clk);
    end
    par_valid = 1'b0; ob_ready = 1'b1;
    chk(ob_valid == 1'b0, "R4 drop valid", 128'(ob_valid), 128'd0);
    chk(par_ready == 1'b1, "R6 ready after", 128'(par_ready), 128'd1);
    @(posedge clk);
    @(negedge clk);
    chk(ob_valid == 1'b0, "R6 no extra take", 128'(ob_valid), 128'd0);
  endtask

  task automatic do_load(input logic [79:0] b, input int stall_mode);
    bit erased = (b == {10{8'hFF}});
    int j = 7, t = 0;
    @(negedge clk);
    chk(rd_ready == 1'b1, "R11 idle ready", 128'(rd_ready), 128'd1);
    rd_valid = 1'b1; rd_bytes = b;
    @(posedge clk);
    @(negedge clk);
    rd_valid = 1'b0;
    if (erased) begin
      chk(rd_erased == 1'b1, "R7 erased pulse", 128'(rd_erased), 128'd1);
      chk(ld_strobe == 1'b0, "R7 no load", 128'(ld_strobe), 128'd0);
      @(posedge clk);
      @(negedge clk);
      chk(rd_erased == 1'b0 && ld_strobe == 1'b0, "R7 one pulse", 128'({rd_erased, ld_strobe}), 128'd0);
      return;
    end
    chk(rd_erased == 1'b0, "R7 not erased", 128'(rd_erased), 128'd0);
    while (j >= 0) begin
      ld_stall = (stall_mode == 0) ? 1'b0 : ((t % 4) == 0);
      #1;
      chk(rd_ready == 1'b0, "R11 busy", 128'(rd_ready), 128'd0);
      if (ld_stall) begin
        chk(ld_strobe == 1'b0, "R10 stalled", 128'(ld_strobe), 128'd0);
        chk(ld_index == 3'(j), "R10 index held", 128'(ld_index), 128'(j));
      end else begin
        chk(ld_strobe == 1'b1, "R9 strobe", 128'(ld_strobe), 128'd1);
        chk(ld_index == 3'(j), "R9 order", 128'(ld_index), 128'(j));
        chk(ld_value == exp_sym(b, j), "R8 value", 128'(ld_value), 128'(exp_sym(b, j)));
        chk(ld_last == (j == 0), "R9 last", 128'(ld_last), 128'(j == 0));
        j--;
      end
      t++;
      @(posedge clk);
      @(negedge clk);
    end
    ld_stall = 1'b0;
    #1;
    chk(ld_strobe == 1'b0 && rd_ready == 1'b1, "R11 done", 128'({ld_strobe, rd_ready}), 128'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; par_valid = 1'b0; ob_ready = 1'b1; rd_valid = 1'b0; ld_stall = 1'b0;
    par_words = '0; rd_bytes = '0;
    repeat (3) @(negedge clk);
    chk(ob_valid == 1'b0 && ld_strobe == 1'b0 && rd_erased == 1'b0, "R12 outputs low",
        128'({ob_valid, ld_strobe, rd_erased}), 128'd0);
    chk(par_ready == 1'b1 && rd_ready == 1'b1, "R12 ready high", 128'({par_ready, rd_ready}), 128'd3);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < 5; i++) begin
      do_pack(VEC[i], i % 2);
      do_load(exp_pack(VEC[i]), (i + 1) % 2);
    end

    // Directed corner cases
    do_load({10{8'hFF}}, 0);                     // R7 erased page
    do_load({{9{8'hFF}}, 8'hFE}, 0);             // R7 one bit clear: loads
    do_load({8'hFE, {9{8'hFF}}}, 1);             // R8 top byte differs
    do_load(80'h0123_4567_89AB_CDEF_A55A, 1);    // R8 mixed
    do_pack(128'hFC00_FC00_FC00_FC00_FC00_FC00_FC00_FC00 | VEC[2], 1); // R1 masked bits

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule